// File: doc/BRIEF.md
# Quad-Word Link Output Sequencer

This block takes sample words from four receive filter channels and from two gain-control units and sends them out a byte-wide link to a DSP. Every transfer is one 16-byte quad-word made of four 4-byte slots. Each slot holds either one I/Q word, with the 16-bit I value in the low half and the 16-bit Q value in the high half, or one 16-bit gain word with two zero bytes above it. Every source has a single-entry holding register. A trigger loads the register. When the sequencer takes the word for a slot, the register is freed.

An 8-bit control input sets the behaviour. Bit 0 picks the source: 0 selects the filter channels and 1 selects AGC data. Bit 1 picks the rotation. Bit 2 turns gain words off when the two AGC units alternate. Bits 6..3 set the start delay. Bit 7 switches the link on. The sequencer first assembles a full quad-word. It then waits for the receiver's data-ready strobe and counts the start delay. After that it sends 16 bytes, least significant byte first, with the link clock enable high for each byte.

The state machine has five states. ST_IDLE goes to ST_COLLECT when bit 7 is set. ST_COLLECT goes to ST_ARMED when slot 3 is filled. ST_ARMED goes to ST_DELAY on data-ready. ST_DELAY goes to ST_SEND when the delay count expires. ST_SEND goes back to ST_COLLECT after the last byte. Every state except ST_IDLE returns to ST_IDLE when bit 7 falls. The mode is latched on leaving ST_IDLE and at the end of each quad-word.

Top module: `lnk_qw_seq`

## Requirements
- R1: After reset, lnk_data is 0, lnk_clk_en is 0, busy is 0 and ovf is all zero.
- R2: While ctrl[7] is 0, lnk_clk_en and busy stay 0, whatever data_rdy and the triggers do.
- R3: A quad-word leaves as 16 consecutive bytes with lnk_clk_en high, least significant byte first. Slot k occupies bytes 4k..4k+3, an I/Q word has I in its low 16 bits, and lnk_data is 0 whenever lnk_clk_en is low.
- R4: With ctrl[0]=0 and ctrl[1]=0, the slots carry channels 0, 1, 0, 1.
- R5: With ctrl[0]=0 and ctrl[1]=1, the slots carry channels 0, 1, 2, 3.
- R6: With ctrl[0]=0, ctrl[2] has no effect on the bytes sent.
- R7: With ctrl[0]=1 and ctrl[1]=1, the slots carry the port's own AGC (parameter OWN_AGC: 0 for A, 1 for B) as I/Q, gain, I/Q, gain, for either value of ctrl[2]. Each gain slot is the gain word that came with the I/Q word in the slot before it, with 16 zero bits above it.
- R8: With ctrl[0]=1, ctrl[1]=0 and ctrl[2]=0, the slots carry AGC A I/Q, AGC A gain, AGC B I/Q, AGC B gain.
- R9: With ctrl[0]=1, ctrl[1]=0 and ctrl[2]=1, the slots carry I/Q words from AGC A, B, A, B and no gain words.
- R10: Once the four slots are filled, a data_rdy seen at a clock edge makes the first byte appear max(ctrl[6:3], MIN_DLY) clock edges later.
- R11: A trigger that arrives while the same source's word is still waiting replaces that word and sets that source's ovf bit. The ovf bit then stays set until reset. The bit order is channels 0..3, then AGC A, then AGC B.
- R12: busy is high from the first delay cycle through the last byte and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 8 | Control byte: source, rotation, gain-off, delay, link enable |
| ch_iq | input | 4*2*SW | Filter channel I/Q words, channel i in bits [i*2*SW +: 2*SW] |
| ch_trig | input | 4 | Per-channel sample-valid pulse |
| agc_iq | input | 2*2*SW | AGC I/Q words, A in the low half |
| agc_gain | input | 2*SW | AGC gain words, A in the low half |
| agc_trig | input | 2 | Per-AGC sample-valid pulse, bit 0 for A |
| data_rdy | input | 1 | Receiver data-ready strobe |
| lnk_data | output | 8 | Link data byte |
| lnk_clk_en | output | 1 | High for each valid link byte |
| busy | output | 1 | Delay count or transfer in progress |
| ovf | output | 6 | Sticky per-source overwrite flags |

## Verification
The bench builds the block with SW=16, MIN_DLY=6 and OWN_AGC=1. With OWN_AGC=1 the single-AGC mode draws from AGC B, so a rotation that wrongly reads AGC A shows up in the bytes. Programmed delays of 0 and 2 exercise the MIN_DLY floor, and delays of 7, 9, 12 and 15 check exact counting above the floor. A filter channel that is triggered twice while the link is off exposes both the overwrite and the sticky flag. That channel's replacement word then has to appear in slot 2 of the next four-channel quad-word.

// File: rtl/lqs_pkg.sv
package lqs_pkg;
    localparam int NCH      = 4;
    localparam int NAGC     = 2;
    localparam int NSRC     = NCH + NAGC;
    localparam int SRC_W    = $clog2(NSRC);
    localparam int AGC_BASE = NCH;
    localparam int NSLOT    = 4;
    localparam int CTRL_W   = 8;
    localparam int DLY_W    = 4;
    localparam int BYTE_W   = 8;
    localparam int B_EN     = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_ARMED,
        ST_DELAY,
        ST_SEND
    } seq_state_e;

    typedef enum logic {
        SK_IQ,
        SK_GAIN
    } slot_kind_e;

    // Mirrors ctrl[6:0]: bit0 agc, bit1 rot, bit2 gain_off, bits 6..3 dly
    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic             gain_off;
        logic             rot;
        logic             agc;
    } mode_t;
endpackage

// File: rtl/lqs_hold.sv
module lqs_hold #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trig,
    input  logic         take,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         pend,
    output logic         ovf
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            pend <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            if (trig) begin
                q <= d;
            end
            pend <= trig | (pend & ~take);
            if (trig && pend && !take) begin
                ovf <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lqs_slot_map.sv
module lqs_slot_map
    import lqs_pkg::*;
#(
    parameter int OWN_AGC = 0
) (
    input  mode_t             mode,
    input  logic [1:0]        slot,
    output logic [SRC_W-1:0]  src,
    output slot_kind_e        kind
);
    always_comb begin
        src  = '0;
        kind = SK_IQ;
        unique case ({mode.agc, mode.rot})
            2'b00: src = SRC_W'(slot[0]);
            2'b01: src = SRC_W'(slot);
            2'b11: begin
                src  = SRC_W'(AGC_BASE + OWN_AGC);
                kind = slot[0] ? SK_GAIN : SK_IQ;
            end
            2'b10: begin
                if (!mode.gain_off) begin
                    src  = SRC_W'(AGC_BASE) + SRC_W'(slot[1]);
                    kind = slot[0] ? SK_GAIN : SK_IQ;
                end else begin
                    src  = SRC_W'(AGC_BASE) + SRC_W'(slot[0]);
                end
            end
        endcase
    end
endmodule

// File: rtl/lqs_fsm.sv
module lqs_fsm
    import lqs_pkg::*;
#(
    parameter int SW      = 16,
    parameter int MIN_DLY = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CTRL_W-1:0]            ctrl,
    input  logic                         data_rdy,
    input  logic [NSRC-1:0]              pend,
    input  logic [NSRC-1:0][3*SW-1:0]    hold_q,
    input  logic [SRC_W-1:0]             src,
    input  slot_kind_e                   kind,
    output mode_t                        mode_q,
    output logic [1:0]                   slot_q,
    output logic [NSRC-1:0]              take,
    output logic [BYTE_W-1:0]            lnk_data,
    output logic                         lnk_clk_en,
    output logic                         busy
);
    localparam int WW    = 2 * SW;
    localparam int QB    = NSLOT * WW / BYTE_W;
    localparam int BI_W  = $clog2(QB);
    localparam int CNT_W = $clog2((1 << DLY_W) + MIN_DLY + 1);

    seq_state_e                     state_q, state_d;
    logic [NSLOT-1:0][WW-1:0]       qbuf;
    logic [QB-1:0][BYTE_W-1:0]      qbytes;
    logic [SW-1:0]                  gain_q;
    logic [CNT_W-1:0]               dcnt, eff;
    logic [BI_W-1:0]                byte_q;
    logic                           en, slot_ok, fill, last_byte, dly_done;

    assign en        = ctrl[B_EN];
    assign slot_ok   = (kind == SK_GAIN) || pend[src];
    assign fill      = (state_q == ST_COLLECT) && en && slot_ok;
    assign last_byte = (byte_q == BI_W'(QB - 1));
    assign eff       = (CNT_W'(mode_q.dly) < CNT_W'(MIN_DLY)) ? CNT_W'(MIN_DLY)
                                                             : CNT_W'(mode_q.dly);
    assign dly_done  = (dcnt == eff - CNT_W'(1));
    assign qbytes    = qbuf;

    always_comb begin
        take = '0;
        if (fill && kind == SK_IQ) begin
            take[src] = 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (en) state_d = ST_COLLECT;
            ST_COLLECT: if (!en) state_d = ST_IDLE;
                        else if (slot_ok && slot_q == 2'd3) state_d = ST_ARMED;
            ST_ARMED:   if (!en) state_d = ST_IDLE;
                        else if (data_rdy) state_d = ST_DELAY;
            ST_DELAY:   if (!en) state_d = ST_IDLE;
                        else if (dly_done) state_d = ST_SEND;
            ST_SEND:    if (!en) state_d = ST_IDLE;
                        else if (last_byte) state_d = ST_COLLECT;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            slot_q <= '0;
            qbuf   <= '0;
            gain_q <= '0;
            dcnt   <= '0;
            byte_q <= '0;
        end else begin
            if ((state_q == ST_IDLE && en) || (state_q == ST_SEND && last_byte)) begin
                mode_q <= mode_t'(ctrl[6:0]);
            end
            if (state_q != ST_COLLECT) begin
                slot_q <= '0;
            end else if (fill) begin
                slot_q <= slot_q + 2'd1;
            end
            if (fill) begin
                if (kind == SK_GAIN) begin
                    qbuf[slot_q] <= WW'(gain_q);
                end else begin
                    qbuf[slot_q] <= hold_q[src][WW-1:0];
                    gain_q       <= hold_q[src][3*SW-1:WW];
                end
            end
            dcnt   <= (state_q == ST_DELAY) ? dcnt + CNT_W'(1) : '0;
            byte_q <= (state_q == ST_SEND) ? byte_q + BI_W'(1) : '0;
        end
    end

    always_comb begin
        lnk_clk_en = (state_q == ST_SEND);
        lnk_data   = lnk_clk_en ? qbytes[byte_q] : '0;
        busy       = (state_q == ST_DELAY) || (state_q == ST_SEND);
    end
endmodule

// File: rtl/lnk_qw_seq.sv
module lnk_qw_seq
    import lqs_pkg::*;
#(
    parameter int SW      = 16,
    parameter int MIN_DLY = 6,
    parameter int OWN_AGC = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CTRL_W-1:0]      ctrl,
    input  logic [NCH*2*SW-1:0]    ch_iq,
    input  logic [NCH-1:0]         ch_trig,
    input  logic [NAGC*2*SW-1:0]   agc_iq,
    input  logic [NAGC*SW-1:0]     agc_gain,
    input  logic [NAGC-1:0]        agc_trig,
    input  logic                   data_rdy,
    output logic [BYTE_W-1:0]      lnk_data,
    output logic                   lnk_clk_en,
    output logic                   busy,
    output logic [NSRC-1:0]        ovf
);
    localparam int HW = 3 * SW;

    logic [NSRC-1:0][HW-1:0] src_d, hold_q;
    logic [NSRC-1:0]         trig, take, pend;
    mode_t                   mode_q;
    logic [1:0]              slot_q;
    logic [SRC_W-1:0]        src;
    slot_kind_e              kind;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i < NCH) begin : g_ch
            assign src_d[i] = {{SW{1'b0}}, ch_iq[i*2*SW +: 2*SW]};
            assign trig[i]  = ch_trig[i];
        end else begin : g_agc
            assign src_d[i] = {agc_gain[(i-NCH)*SW +: SW], agc_iq[(i-NCH)*2*SW +: 2*SW]};
            assign trig[i]  = agc_trig[i-NCH];
        end
        lqs_hold #(.W(HW)) u_hold (
            .clk  (clk),
            .rst_n(rst_n),
            .trig (trig[i]),
            .take (take[i]),
            .d    (src_d[i]),
            .q    (hold_q[i]),
            .pend (pend[i]),
            .ovf  (ovf[i])
        );
    end

    lqs_slot_map #(.OWN_AGC(OWN_AGC)) u_map (
        .mode(mode_q),
        .slot(slot_q),
        .src (src),
        .kind(kind)
    );

    lqs_fsm #(.SW(SW), .MIN_DLY(MIN_DLY)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .data_rdy  (data_rdy),
        .pend      (pend),
        .hold_q    (hold_q),
        .src       (src),
        .kind      (kind),
        .mode_q    (mode_q),
        .slot_q    (slot_q),
        .take      (take),
        .lnk_data  (lnk_data),
        .lnk_clk_en(lnk_clk_en),
        .busy      (busy)
    );
endmodule

// File: rtl/lqs_chk.sv
module lqs_chk #(
    parameter int MIN_DLY = 6,
    parameter int NSRC    = 6,
    parameter int QB      = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            link_on,
    input logic [7:0]      lnk_data,
    input logic            lnk_clk_en,
    input logic            busy,
    input logic [NSRC-1:0] ovf
);
    logic [5:0] run_q, dly_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            dly_q <= '0;
        end else begin
            run_q <= lnk_clk_en ? ((run_q == 6'd63) ? run_q : run_q + 6'd1) : '0;
            dly_q <= (busy && !lnk_clk_en) ? ((dly_q == 6'd63) ? dly_q : dly_q + 6'd1)
                                           : (busy ? dly_q : '0);
        end
    end

    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !link_on |=> (!lnk_clk_en && !busy));

    a_r12_clk_en_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_clk_en |-> busy);

    a_r3_full_quad: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lnk_clk_en) && $past(link_on)) |-> (run_q == 6'(QB)));

    a_r3_quad_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 6'(QB));

    a_r3_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lnk_clk_en |-> (lnk_data == 8'd0));

    a_r10_min_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lnk_clk_en) |-> (dly_q >= 6'(MIN_DLY)));

    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf & $past(ovf)) == $past(ovf)));
endmodule

bind lnk_qw_seq lqs_chk #(.MIN_DLY(MIN_DLY), .NSRC(6), .QB(16)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_on   (ctrl[7]),
    .lnk_data  (lnk_data),
    .lnk_clk_en(lnk_clk_en),
    .busy      (busy),
    .ovf       (ovf)
);

// File: tb/tb_lnk_qw_seq.sv
module tb_lnk_qw_seq;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [7:0]   ctrl;
    logic [127:0] ch_iq;
    logic [3:0]   ch_trig;
    logic [63:0]  agc_iq;
    logic [31:0]  agc_gain;
    logic [1:0]   agc_trig;
    logic         data_rdy;
    logic [7:0]   lnk_data;
    logic         lnk_clk_en, busy;
    logic [5:0]   ovf;
    int           n_chk = 0, n_bad = 0;
    bit           done = 0;

    always #10 clk = ~clk;

    lnk_qw_seq #(.SW(16), .MIN_DLY(6), .OWN_AGC(1)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .ch_iq(ch_iq), .ch_trig(ch_trig),
        .agc_iq(agc_iq), .agc_gain(agc_gain), .agc_trig(agc_trig), .data_rdy(data_rdy),
        .lnk_data(lnk_data), .lnk_clk_en(lnk_clk_en), .busy(busy), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic trig_ch(input int i, input logic [31:0] w);
        @(negedge clk);
        ch_iq[i*32 +: 32] = w;
        ch_trig[i] = 1'b1;
        @(negedge clk);
        ch_trig[i] = 1'b0;
    endtask

    task automatic trig_agc(input int a, input logic [31:0] w, input logic [15:0] g);
        @(negedge clk);
        agc_iq[a*32 +: 32]   = w;
        agc_gain[a*16 +: 16] = g;
        agc_trig[a] = 1'b1;
        @(negedge clk);
        agc_trig[a] = 1'b0;
    endtask

    task automatic set_ctrl(input logic [7:0] c);
        @(negedge clk);
        ctrl = 8'h00;
        repeat (2) @(negedge clk);
        ctrl = c;
    endtask

    // Pulse data_rdy, measure the start delay, capture and compare 16 bytes.
    task automatic xfer(input logic [127:0] exp, input int eff, input string req);
        int n;
        logic [127:0] got;
        bit en_ok;
        repeat (8) @(negedge clk);
        data_rdy = 1'b1;
        @(negedge clk);
        data_rdy = 1'b0;
        n = 1;
        chk(busy == 1'b1, "R12 busy in delay", 128'(busy), 128'd1);
        while (!lnk_clk_en && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(n == eff + 1, "R10 start delay", 128'(n), 128'(eff + 1));
        got = '0;
        got[7:0] = lnk_data;
        en_ok = lnk_clk_en && busy;
        for (int b = 1; b < 16; b++) begin
            @(negedge clk);
            en_ok = en_ok && lnk_clk_en && busy;
            got[b*8 +: 8] = lnk_data;
        end
        chk(en_ok, "R3 clk_en held for 16 bytes", 128'(en_ok), 128'd1);
        chk(got == exp, req, got, exp);
        @(negedge clk);
        chk(!lnk_clk_en && !busy && lnk_data == 8'd0, "R12 R3 quiet after quad",
            {lnk_clk_en, busy, lnk_data}, 128'd0);
    endtask

    task automatic t_reset;
        chk(lnk_data == 8'd0 && !lnk_clk_en && !busy && ovf == 6'd0, "R1 reset outputs",
            {ovf, lnk_data, lnk_clk_en, busy}, 128'd0);
    endtask

    task automatic t_disabled;
        bit seen_en, seen_busy;
        ctrl = 8'h02;
        trig_ch(2, 32'h2222_1111);
        trig_ch(2, 32'h2B2B_1A1A);
        @(negedge clk);
        data_rdy = 1'b1;
        @(negedge clk);
        data_rdy = 1'b0;
        seen_en = 0;
        seen_busy = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            seen_en   |= lnk_clk_en;
            seen_busy |= busy;
        end
        chk(!seen_en, "R2 no clk_en while off", 128'(seen_en), 128'd0);
        chk(!seen_busy, "R2 no busy while off", 128'(seen_busy), 128'd0);
        chk(ovf == 6'b000100, "R11 overwrite flag", 128'(ovf), 128'h4);
    endtask

    task automatic t_four_ch;
        set_ctrl(8'h82);
        trig_ch(0, 32'h0A00_0A01);
        trig_ch(1, 32'h1B00_1B01);
        trig_ch(3, 32'h3D00_3D01);
        xfer({32'h3D00_3D01, 32'h2B2B_1A1A, 32'h1B00_1B01, 32'h0A00_0A01}, 6,
             "R5 R11 four-channel payload");
        chk(ovf == 6'b000100, "R11 ovf sticky", 128'(ovf), 128'h4);
    endtask

    task automatic t_two_ch(input logic [7:0] c, input int eff, input string req);
        set_ctrl(c);
        trig_ch(0, 32'h5555_0001);
        trig_ch(1, 32'h6666_0002);
        repeat (3) @(negedge clk);
        trig_ch(0, 32'h7777_0003);
        trig_ch(1, 32'h8888_0004);
        xfer({32'h8888_0004, 32'h7777_0003, 32'h6666_0002, 32'h5555_0001}, eff, req);
    endtask

    task automatic t_agc_own;
        set_ctrl(8'h80 | (8'd2 << 3) | 8'h07);
        trig_agc(1, 32'hB0B0_0B0B, 16'hC001);
        repeat (2) @(negedge clk);
        trig_agc(1, 32'hB1B1_1B1B, 16'hC002);
        xfer({32'h0000_C002, 32'hB1B1_1B1B, 32'h0000_C001, 32'hB0B0_0B0B}, 6,
             "R7 own AGC with gain");
    endtask

    task automatic t_agc_alt_gain;
        set_ctrl(8'h80 | (8'd7 << 3) | 8'h01);
        trig_agc(0, 32'hA0A0_0A0A, 16'h1234);
        trig_agc(1, 32'hB2B2_2B2B, 16'h5678);
        xfer({32'h0000_5678, 32'hB2B2_2B2B, 32'h0000_1234, 32'hA0A0_0A0A}, 7,
             "R8 alternating AGC with gain");
    endtask

    task automatic t_agc_alt_nogain;
        set_ctrl(8'h80 | (8'd15 << 3) | 8'h05);
        trig_agc(0, 32'hA1A1_0001, 16'hEEEE);
        trig_agc(1, 32'hB3B3_0002, 16'hDDDD);
        repeat (2) @(negedge clk);
        trig_agc(0, 32'hA2A2_0003, 16'hCCCC);
        trig_agc(1, 32'hB4B4_0004, 16'hBBBB);
        xfer({32'hB4B4_0004, 32'hA2A2_0003, 32'hB3B3_0002, 32'hA1A1_0001}, 15,
             "R9 alternating AGC without gain");
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ctrl = 8'h00; ch_iq = '0; ch_trig = '0;
        agc_iq = '0; agc_gain = '0; agc_trig = '0; data_rdy = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_four_ch();
        t_two_ch(8'h80 | (8'd9 << 3) | 8'h04, 9, "R4 R6 two-channel with bit2 set");
        t_two_ch(8'h80 | (8'd12 << 3), 12, "R4 R6 two-channel with bit2 clear");
        t_agc_own();
        t_agc_alt_gain();
        t_agc_alt_nogain();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule